// File: doc/BRIEF.md
# Bit-Error Tester Sticky Status and Interrupt Unit

This unit is the status and interrupt front end of a bit-error-rate tester. Every clock it samples four real-time signals from the tester core: a performance-monitor update flag, a one-cycle bit-error event, a flag that says the error count is nonzero, and a flag for lost pattern synchronisation. It turns each of them into a sticky bit. Each sticky bit is masked by its own enable, and the masked bits drive one registered, active-high interrupt line.

The sticky bits do not all capture the same condition. The monitor-update and error-count bits record only a 0-to-1 change of their source. The sync-loss bit records a change in either direction. The bit-error bit records any cycle in which the error event is high.

Software reaches the unit through a plain synchronous byte bus. Read data is combinational from the address. Writes take effect on the clock edge. The sticky register sits at byte address 0x8E and is cleared by writing ones. The enable register sits at 0x90 and can be read and written.

Top module: `bert_stat_irq`

## Requirements
- R1: After reset all sticky bits are 0, all enables are 0 (a read of 0x90 gives 0x00), and `irq_o` is 0.
- R2: Sticky bit 3 (monitor update) sets on the clock edge that samples `pm_upd_i` high after it was sampled low on the previous edge. A level that stays high does not set it again.
- R3: Sticky bit 2 (bit error) sets on every clock edge that samples `bit_err_i` high.
- R4: Sticky bit 1 (error count nonzero) sets only when `err_cnt_nz_i` goes from 0 to 1 between two sampling edges.
- R5: Sticky bit 0 (sync loss) sets when `sync_loss_i` changes between two sampling edges, whether it rises or falls.
- R6: Reading 0x8E returns the sticky bits in bits 3..0. Writing 0x8E clears each sticky bit whose write-data bit is 1. A 0 in the write data leaves that bit unchanged.
- R7: If a set condition and a clear of the same bit fall on the same edge, the bit ends up set.
- R8: The enable register at 0x90 holds write-data bits 3..0. Bit k enables sticky bit k, and 1 means enabled. Reads return the enables in bits 3..0. Bits 7..4 of every read are 0.
- R9: `irq_o` equals the OR over k of (sticky bit k AND enable k), one clock edge after those values are in place.
- R10: A read of any address other than 0x8E or 0x90 returns 0x00. A write to any other address changes neither register.
- R11: The first clock edge after reset release records no level transition. A level input that is already high when reset is released does not set its sticky bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pm_upd_i | input | 1 | Real-time performance-monitor update flag |
| bit_err_i | input | 1 | Bit-error event, high for each errored cycle |
| err_cnt_nz_i | input | 1 | Real-time error-count-nonzero flag |
| sync_loss_i | input | 1 | Real-time out-of-sync flag |
| bus_addr_i | input | 8 | Register byte address |
| bus_wen_i | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
Directed sequences separate the three capture rules. Each level input is pulsed low and then high, or held high across a clear, which shows whether a bit captures edges or levels. The sync-loss input is moved in both directions. Reset is released while the level inputs are already high, which checks that a level present at reset records no edge. Further directed steps put a set and a clear on the same edge, write zeros, and write an unmapped address. After that, thousands of random cycles mix sparse error events, level toggles, and reads and writes to both registers and to unmapped addresses. A bench reference model of the sticky bits, the enables and the interrupt register catches wrong masking and interrupt timing that is off by one cycle.

// File: rtl/bert_stat_pkg.sv
package bert_stat_pkg;
  localparam int unsigned NSRC    = 4;
  localparam int unsigned IDX_PMU = 3;
  localparam int unsigned IDX_ERR = 2;
  localparam int unsigned IDX_CNT = 1;
  localparam int unsigned IDX_OOS = 0;

  typedef logic [NSRC-1:0] src_vec_t;

  // capture rule per source bit: pulse = level sampled, both = any change,
  // otherwise rising edge only
  localparam src_vec_t PULSE_MASK = src_vec_t'(1) << IDX_ERR;
  localparam src_vec_t BOTH_MASK  = src_vec_t'(1) << IDX_OOS;
endpackage

// File: rtl/bert_evt_detect.sv
module bert_evt_detect
  import bert_stat_pkg::*;
#(
  parameter int unsigned N          = NSRC,
  parameter logic [N-1:0] PULSE_SEL = PULSE_MASK,
  parameter logic [N-1:0] BOTH_SEL  = BOTH_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] set_o
);
  logic         prm_q;
  logic         prm_d;
  logic [N-1:0] dly_q;
  logic [N-1:0] dly_d;

  always_comb begin
    prm_d = 1'b1;
    dly_d = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prm_q <= 1'b0;
      dly_q <= '0;
    end else begin
      prm_q <= prm_d;
      dly_q <= dly_d;
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_src
    if (PULSE_SEL[gi]) begin : g_pulse
      assign set_o[gi] = lvl_i[gi];
    end else if (BOTH_SEL[gi]) begin : g_both
      assign set_o[gi] = prm_q & (lvl_i[gi] ^ dly_q[gi]);
    end else begin : g_rise
      assign set_o[gi] = prm_q & lvl_i[gi] & ~dly_q[gi];
    end
  end
endmodule

// File: rtl/bert_sticky_bank.sv
module bert_sticky_bank
  import bert_stat_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lat_o
);
  logic [N-1:0] lat_q;
  logic [N-1:0] lat_d;
  logic         lat_ce;

  always_comb begin
    lat_ce = |(set_i | clr_i);
    lat_d  = (lat_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (lat_ce) begin
      lat_q <= lat_d;
    end
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/bert_stat_regif.sv
module bert_stat_regif
  import bert_stat_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h8E,
  parameter logic [ADDR_W-1:0] IEN_ADDR  = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wen_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   lat_i,
  output logic [NSRC-1:0]   clr_o,
  output logic [NSRC-1:0]   en_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic            sel_stat;
  logic            sel_ien;
  logic            en_ce;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] en_d;
  logic            unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:NSRC];

  always_comb begin
    sel_stat = (addr_i == STAT_ADDR);
    sel_ien  = (addr_i == IEN_ADDR);
    en_ce    = wen_i & sel_ien;
    en_d     = wdata_i[NSRC-1:0];
    clr_o    = (wen_i & sel_stat) ? wdata_i[NSRC-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_stat) begin
      rdata_o[NSRC-1:0] = lat_i;
    end else if (sel_ien) begin
      rdata_o[NSRC-1:0] = en_q;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/bert_stat_irq.sv
module bert_stat_irq
  import bert_stat_pkg::*;
#(
  parameter int unsigned ADDR_W          = 8,
  parameter int unsigned DATA_W          = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h8E,
  parameter logic [ADDR_W-1:0] IEN_ADDR  = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pm_upd_i,
  input  logic              bit_err_i,
  input  logic              err_cnt_nz_i,
  input  logic              sync_loss_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wen_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  src_vec_t src_lvl;
  src_vec_t src_set;
  src_vec_t lat_q;
  src_vec_t clr_v;
  src_vec_t en_q;
  logic     irq_q;
  logic     irq_d;

  always_comb begin
    src_lvl          = '0;
    src_lvl[IDX_PMU] = pm_upd_i;
    src_lvl[IDX_ERR] = bit_err_i;
    src_lvl[IDX_CNT] = err_cnt_nz_i;
    src_lvl[IDX_OOS] = sync_loss_i;
  end

  bert_evt_detect #(
    .N        (NSRC),
    .PULSE_SEL(PULSE_MASK),
    .BOTH_SEL (BOTH_MASK)
  ) u_det (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl_i(src_lvl),
    .set_o(src_set)
  );

  bert_sticky_bank #(
    .N(NSRC)
  ) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(src_set),
    .clr_i(clr_v),
    .lat_o(lat_q)
  );

  bert_stat_regif #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STAT_ADDR(STAT_ADDR),
    .IEN_ADDR (IEN_ADDR)
  ) u_regif (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (bus_addr_i),
    .wen_i  (bus_wen_i),
    .wdata_i(bus_wdata_i),
    .lat_i  (lat_q),
    .clr_o  (clr_v),
    .en_o   (en_q),
    .rdata_o(bus_rdata_o)
  );

  always_comb begin
    irq_d = |(lat_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/bert_stat_irq_chk.sv
module bert_stat_irq_chk
  import bert_stat_pkg::*;
#(
  parameter int unsigned ADDR_W          = 8,
  parameter int unsigned DATA_W          = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h8E,
  parameter logic [ADDR_W-1:0] IEN_ADDR  = 8'h90
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_err_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wen_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_o,
  input logic [NSRC-1:0]   lat_q,
  input logic [NSRC-1:0]   en_q
);
  logic [NSRC-1:0] wclr;
  assign wclr = (bus_wen_i && bus_addr_i == STAT_ADDR) ? bus_wdata_i[NSRC-1:0] : '0;

  AST_ERR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err_i |=> lat_q[IDX_ERR]); // R3

  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lat_q) & ~lat_q & ~$past(wclr)) == '0)); // R6

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(lat_q) & $past(en_q)))); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_o[DATA_W-1:NSRC] == '0); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i != STAT_ADDR && bus_addr_i != IEN_ADDR) |-> bus_rdata_o == '0); // R10

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wen_i && bus_addr_i == IEN_ADDR) |=> $stable(en_q)); // R10
endmodule

bind bert_stat_irq bert_stat_irq_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .STAT_ADDR(STAT_ADDR),
  .IEN_ADDR (IEN_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_err_i  (bit_err_i),
  .bus_addr_i (bus_addr_i),
  .bus_wen_i  (bus_wen_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o),
  .lat_q      (lat_q),
  .en_q       (en_q)
);

// File: tb/bert_stat_irq_tb.sv
module bert_stat_irq_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_STAT = 8'h8E;
  localparam logic [7:0] A_IEN  = 8'h90;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pm = 1'b0, er = 1'b0, cn = 1'b0, os = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wen = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [3:0] m_lat, m_en, m_dly;
  logic       m_prm, m_irq;

  always #(CLK_P/2) clk = ~clk;

  bert_stat_irq u_dut (
    .clk(clk), .rst_n(rst_n),
    .pm_upd_i(pm), .bit_err_i(er), .err_cnt_nz_i(cn), .sync_loss_i(os),
    .bus_addr_i(addr), .bus_wen_i(wen), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == A_STAT) return {4'h0, m_lat};
    if (a == A_IEN)  return {4'h0, m_en};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_lat = 4'h0; m_en = 4'h0; m_dly = 4'h0; m_prm = 1'b0; m_irq = 1'b0;
  endtask

  // drive one cycle, advance model, compare after the edge
  task automatic step(input logic p, input logic e, input logic c, input logic o,
                      input logic w, input logic [7:0] a, input logic [7:0] d);
    logic [3:0] lvl, set, clr;
    @(negedge clk);
    pm = p; er = e; cn = c; os = o; wen = w; addr = a; wdata = d;
    lvl = {p, e, c, o};
    set[3] = m_prm & lvl[3] & ~m_dly[3];
    set[2] = lvl[2];
    set[1] = m_prm & lvl[1] & ~m_dly[1];
    set[0] = m_prm & (lvl[0] ^ m_dly[0]);
    clr = (w && a == A_STAT) ? d[3:0] : 4'h0;
    m_irq = |(m_lat & m_en);
    m_lat = (m_lat & ~clr) | set;
    if (w && a == A_IEN) m_en = d[3:0];
    m_dly = lvl;
    m_prm = 1'b1;
    @(posedge clk);
    #1;
    chk("R9 irq", {7'h0, irq}, {7'h0, m_irq});
    if (a == A_STAT)     chk("R6 stat read", rdata, exp_rd(a));
    else if (a == A_IEN) chk("R8 enable read", rdata, exp_rd(a));
    else                 chk("R10 unmapped read", rdata, exp_rd(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    model_reset();
    // levels high through reset: R11
    pm = 1'b1; cn = 1'b1; os = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq at reset", {7'h0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 0, 1, 1, 0, A_STAT, 8'h00);
    chk("R11 no edge on release", rdata, 8'h00);
    chk("R1 irq after reset", {7'h0, irq}, 8'h00);
    step(1, 0, 1, 1, 0, A_IEN, 8'h00);
    chk("R1 enables zero", rdata, 8'h00);
    // R2 monitor update rising edge only
    step(0, 0, 1, 1, 0, A_STAT, 8'h00);
    chk("R2 fall ignored", rdata, 8'h00);
    step(1, 0, 1, 1, 0, A_STAT, 8'h00);
    chk("R2 rise sets bit3", rdata, 8'h08);
    step(1, 0, 1, 1, 1, A_STAT, 8'h08);
    chk("R6 write one clears", rdata, 8'h00);
    step(1, 0, 1, 1, 0, A_STAT, 8'h00);
    chk("R2 held level no reset", rdata, 8'h00);
    // R4 error count rising edge only
    step(1, 0, 0, 1, 0, A_STAT, 8'h00);
    chk("R4 fall ignored", rdata, 8'h00);
    step(1, 0, 1, 1, 0, A_STAT, 8'h00);
    chk("R4 rise sets bit1", rdata, 8'h02);
    // R5 sync loss both edges
    step(1, 0, 1, 0, 0, A_STAT, 8'h00);
    chk("R5 fall sets bit0", rdata, 8'h03);
    step(1, 0, 1, 0, 1, A_STAT, 8'h01);
    chk("R6 clear bit0 only", rdata, 8'h02);
    step(1, 0, 1, 1, 0, A_STAT, 8'h00);
    chk("R5 rise sets bit0", rdata, 8'h03);
    step(1, 0, 1, 1, 1, A_STAT, 8'h00);
    chk("R6 write zero keeps", rdata, 8'h03);
    // R7 set beats clear, R3 error event
    step(1, 1, 1, 1, 1, A_STAT, 8'h0F);
    chk("R7 set wins over clear", rdata, 8'h04);
    chk("R3 error latched", {7'h0, rdata[2]}, 8'h01);
    // R8 / R9 enables and interrupt timing
    step(1, 0, 1, 1, 1, A_IEN, 8'hF4);
    chk("R8 enable write read", rdata, 8'h04);
    chk("R9 irq not yet", {7'h0, irq}, 8'h00);
    step(1, 0, 1, 1, 0, A_IEN, 8'h00);
    chk("R9 irq one cycle later", {7'h0, irq}, 8'h01);
    // R10 unmapped
    step(1, 0, 1, 1, 1, 8'h91, 8'hFF);
    chk("R10 unmapped reads zero", rdata, 8'h00);
    step(1, 0, 1, 1, 0, A_IEN, 8'h00);
    chk("R10 unmapped write ignored", rdata, 8'h04);
    step(1, 0, 1, 1, 1, A_STAT, 8'h04);
    chk("R9 irq lags clear", {7'h0, irq}, 8'h01);
    step(1, 0, 1, 1, 0, A_STAT, 8'h00);
    chk("R9 irq drops", {7'h0, irq}, 8'h00);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic p, e, c, o, w;
      logic [7:0] a, d;
      int op;
      p = ($urandom_range(3) == 0) ? ~pm : pm;
      c = ($urandom_range(3) == 0) ? ~cn : cn;
      o = ($urandom_range(3) == 0) ? ~os : os;
      e = ($urandom_range(7) == 0);
      d = 8'($urandom);
      op = $urandom_range(5);
      case (op)
        0: begin w = 0; a = A_STAT; end
        1: begin w = 0; a = A_IEN; end
        2: begin w = 1; a = A_STAT; end
        3: begin w = 1; a = A_IEN; end
        4: begin w = 1; a = 8'($urandom); end
        default: begin w = 0; a = 8'($urandom); end
      endcase
      step(p, e, c, o, w, a, d);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule